// File: doc/BRIEF.md
# Gated Event Counter with Empty-Window Policy

This block counts rising edges of an asynchronous event line, such as pulses from a single-photon detector, inside the active windows of an asynchronous gate line. In the default per-window operation the count restarts at every gate opening. When the gate closes, the count becomes one sample, and the sample goes into a small output queue that is drained through a valid/ready handshake. A typical gate is 50 ns open and 950 ns closed at a 1 MHz rate, with at most one 40 ns event pulse per window.

A two-bit policy input decides what a window with no events produces. The block can repeat the previous sample, emit zero, or emit nothing and raise a sticky gap error. A separate accumulate input turns the block into a paused totaliser. In that mode, event edges are counted only while the gate is open, the total is never cleared by the gate, and a sample strobe reads it out.

Top module: `gated_event_counter`

## Requirements
- R1: With `rst_n` low at a clock edge, the queue empties, both sticky flags clear, and the running count, the saturation state and the remembered previous sample all return to zero.
- R2: In per-window operation (`accum_mode`=0), only event rising edges seen while the synchronised gate is high are counted. Exactly one closing of the gate yields at most one sample.
- R3: Each gate opening in per-window operation restarts the count from zero, so no sample includes edges from an earlier window.
- R4: An event rising edge that reaches the counter in the same cycle as the gate closing is counted into the window that is closing.
- R5: Policy `win_mode`=2'b00 (repeat): a window with a count of zero emits the previous sample again, with its value and its saturation bit.
- R6: Policy `win_mode`=2'b01 (and 2'b11): a window with no event edges emits a sample of exactly zero.
- R7: Policy `win_mode`=2'b10 (strict): a closing with no event rising edge since the previous closing, or since reset, emits no sample and sets `err_gap`. The flag stays set until `clear_flags` is pulsed.
- R8: With `accum_mode`=1, the count grows only while the gate is high, holds while it is low, and is never cleared by the gate. Gate closings emit nothing. Each `sample_strobe` cycle emits the current total, including an edge counted in that cycle.
- R9: The count saturates at all ones of `CNT_W` bits. `out_sat` is 1 only on a sample whose count would have gone past all ones, and such a sample reads all ones.
- R10: The queue holds `FIFO_DEPTH` samples and shows `out_count`/`out_sat` stable while `out_valid` is high and `out_ready` is low. A sample arriving while the queue is full (with no pop that cycle) is dropped and sets `err_overrun`, which stays set until `clear_flags`.
- R11: At a clock of 100 MHz, a 4-cycle event pulse is counted exactly once. A 5-cycle gate followed by 95 idle cycles works as a normal window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_in | input | 1 | Gate level, asynchronous, high = window open |
| event_in | input | 1 | Event pulses, asynchronous |
| win_mode | input | 2 | Empty-window policy: 00 repeat, 01 zero, 10 strict, 11 zero |
| accum_mode | input | 1 | 1 = paused totaliser, 0 = per-window samples |
| sample_strobe | input | 1 | Readout request in accumulate mode, synchronous |
| clear_flags | input | 1 | Clears both sticky error flags |
| out_valid | output | 1 | Queue head holds a sample |
| out_ready | input | 1 | Consumer takes the head sample |
| out_count | output | CNT_W | Sample count |
| out_sat | output | 1 | Sample saturated |
| err_gap | output | 1 | Sticky strict-mode gap error |
| err_overrun | output | 1 | Sticky queue-overrun error |

## Verification
The bench builds the block with `CNT_W`=6 and keeps the other defaults. With this width, saturation at 63 can be reached in a few hundred cycles, and the bench can test both an exact count of 63 without the flag and an overflowing window with the flag. The queue depth of 8 stays, so ten unread windows are enough to exercise the drop and overrun path. The 2-flop synchroniser depth stays as well, so gate and event inputs driven in the same cycle stay aligned. This is what lets the bench set up the closing-cycle event case.

// File: rtl/gec_pkg.sv
// Shared constants for the gated event counter.
// Assumes: the policy code is a 2-bit field; the unlisted code 2'b11 behaves as zero.
package gec_pkg;
    localparam logic [1:0] WM_REPEAT = 2'b00;
    localparam logic [1:0] WM_ZERO   = 2'b01;
    localparam logic [1:0] WM_STRICT = 2'b10;
endpackage

// File: rtl/gec_sync_edge.sv
// Multi-flop synchroniser plus edge detector for one asynchronous line.
// Assumes: STAGES >= 2; pulses last at least one clock so that one edge is seen.
module gec_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] shreg;
    logic              prev;

    // Shift the raw input through the synchroniser chain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            prev  <= 1'b0;
        end else begin
            shreg <= {shreg[STAGES-2:0], din};
            prev  <= shreg[STAGES-1];
        end
    end

    // Edge flags compare the synchronised level with its delayed copy.
    always_comb begin
        level = shreg[STAGES-1];
        rise  = level & ~prev;
        fall  = ~level & prev;
    end
endmodule

// File: rtl/gec_count_core.sv
// Counting engine: windowed or accumulated event counting, empty-window policy,
// saturation tracking and the choice of which sample to emit.
// Assumes: synchronised, single-cycle edge pulses; modes held steady between resets.
module gec_count_core
    import gec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_lvl,
    input  logic             gate_rise,
    input  logic             gate_fall,
    input  logic             ev_rise,
    input  logic [1:0]       win_mode,
    input  logic             accum_mode,
    input  logic             sample_strobe,
    output logic             push,
    output logic [CNT_W-1:0] push_cnt,
    output logic             push_sat,
    output logic             gap_set
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt, cnt_inc, last_cnt;
    logic             ovf, ovf_inc, last_sat;
    logic             seen_ev;
    logic             ev_en, any_ev, closing;

    // Count enable covers the open window and the closing cycle; saturate at all ones.
    always_comb begin
        ev_en   = ev_rise & (gate_lvl | gate_fall);
        cnt_inc = (ev_en && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
        ovf_inc = ovf | (ev_en & (cnt == CNT_MAX));
        any_ev  = seen_ev | ev_rise;
        closing = gate_fall & ~accum_mode;
    end

    // Decide whether a sample leaves this cycle and what it carries.
    always_comb begin
        push     = 1'b0;
        push_cnt = cnt_inc;
        push_sat = ovf_inc;
        gap_set  = 1'b0;
        if (accum_mode) begin
            push = sample_strobe;
        end else if (closing) begin
            case (win_mode)
                WM_REPEAT: begin
                    push = 1'b1;
                    if (cnt_inc == '0) begin
                        push_cnt = last_cnt;
                        push_sat = last_sat;
                    end
                end
                WM_STRICT: begin
                    push    = any_ev;
                    gap_set = ~any_ev;
                end
                default: push = 1'b1;
            endcase
        end
    end

    // Running count: restarts on a gate opening unless accumulating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (gate_rise && !accum_mode) begin
            cnt <= ev_en ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
            ovf <= 1'b0;
        end else begin
            cnt <= cnt_inc;
            ovf <= ovf_inc;
        end
    end

    // Remember whether any event edge arrived since the last closing.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_ev <= 1'b0;
        else if (closing) seen_ev <= 1'b0;
        else if (ev_rise) seen_ev <= 1'b1;
    end

    // Keep the most recent emitted sample for the repeat policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cnt <= '0;
            last_sat <= 1'b0;
        end else if (push) begin
            last_cnt <= push_cnt;
            last_sat <= push_sat;
        end
    end
endmodule

// File: rtl/gec_sample_fifo.sv
// Small sample queue with a valid/ready read side and a drop-on-full write side.
// Assumes: DEPTH is a power of two; a pop in the same cycle makes room for a push.
module gec_sample_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         not_empty,
    output logic         full,
    output logic         dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   level;
    logic          do_push, do_pop;

    // Status and handshake qualifiers.
    always_comb begin
        not_empty = (level != '0);
        full      = (level == (AW+1)'(DEPTH));
        do_pop    = pop & not_empty;
        do_push   = push & (~full | do_pop);
        dropped   = push & full & ~do_pop;
        rdata     = mem[rd_ptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/gated_event_counter.sv
// Top: synchronises gate and event lines, counts per window or in accumulate mode,
// queues samples and keeps the sticky gap and overrun flags.
// Assumes: clock fast enough that the shortest pulse spans at least one clock.
module gated_event_counter #(
    parameter int CNT_W       = 16,
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_in,
    input  logic             event_in,
    input  logic [1:0]       win_mode,
    input  logic             accum_mode,
    input  logic             sample_strobe,
    input  logic             clear_flags,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CNT_W-1:0] out_count,
    output logic             out_sat,
    output logic             err_gap,
    output logic             err_overrun
);
    localparam int NLINES = 2;
    localparam int SMP_W  = CNT_W + 1;

    logic [NLINES-1:0] raw, lvl, rise, fall;
    logic              push, push_sat, gap_set, dropped, fifo_full;
    logic [CNT_W-1:0]  push_cnt;
    logic [SMP_W-1:0]  head;

    assign raw = {event_in, gate_in};

    // One synchroniser and edge detector per asynchronous line.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        gec_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(raw[g]),
            .level(lvl[g]), .rise(rise[g]), .fall(fall[g])
        );
    end

    gec_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .gate_lvl(lvl[0]), .gate_rise(rise[0]), .gate_fall(fall[0]),
        .ev_rise(rise[1]),
        .win_mode(win_mode), .accum_mode(accum_mode), .sample_strobe(sample_strobe),
        .push(push), .push_cnt(push_cnt), .push_sat(push_sat), .gap_set(gap_set)
    );

    gec_sample_fifo #(.W(SMP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .wdata({push_sat, push_cnt}),
        .pop(out_ready), .rdata(head),
        .not_empty(out_valid), .full(fifo_full), .dropped(dropped)
    );

    // Unpack the queue head onto the output ports.
    always_comb begin
        out_count = head[CNT_W-1:0];
        out_sat   = head[CNT_W];
    end

    // Sticky error flags; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_gap     <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (gap_set)          err_gap <= 1'b1;
            else if (clear_flags) err_gap <= 1'b0;
            if (dropped)          err_overrun <= 1'b1;
            else if (clear_flags) err_overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/gec_checker.sv
// Temporal checks on the gated event counter, attached by bind.
// Assumes: reset is applied from time zero.
module gec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CNT_W-1:0] out_count,
    input logic             out_sat,
    input logic             err_gap,
    input logic             err_overrun,
    input logic             clear_flags,
    input logic             fifo_full,
    input logic [1:0]       win_mode,
    input logic             accum_mode
);
    a_r10_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_count) && $stable(out_sat));

    a_r10_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(fifo_full));

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun && !clear_flags |=> err_overrun);

    a_r7_gap_only_strict: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_gap) |-> $past(win_mode == 2'b10 && !accum_mode));

    a_r7_gap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_gap && !clear_flags |=> err_gap);

    a_r9_sat_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sat |-> (&out_count));
endmodule

bind gated_event_counter gec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count), .out_sat(out_sat), .err_gap(err_gap),
    .err_overrun(err_overrun), .clear_flags(clear_flags), .fifo_full(fifo_full),
    .win_mode(win_mode), .accum_mode(accum_mode)
);

// File: tb/sim_gated_event_counter.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_gated_event_counter;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gate_in = 1'b0, event_in = 1'b0;
    logic [1:0]    win_mode = 2'b01;
    logic          accum_mode = 1'b0, sample_strobe = 1'b0, clear_flags = 1'b0;
    logic          out_ready = 1'b0;
    logic          out_valid, out_sat, err_gap, err_overrun;
    logic [CW-1:0] out_count;
    int            n_checks = 0, n_fail = 0, cycles = 0;

    gated_event_counter #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .event_in(event_in),
        .win_mode(win_mode), .accum_mode(accum_mode), .sample_strobe(sample_strobe),
        .clear_flags(clear_flags), .out_valid(out_valid), .out_ready(out_ready),
        .out_count(out_count), .out_sat(out_sat), .err_gap(err_gap),
        .err_overrun(err_overrun)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; gate_in = 0; event_in = 0; sample_strobe = 0; clear_flags = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ev_pulse();
        event_in = 1'b1; repeat (2) @(negedge clk);
        event_in = 1'b0; repeat (2) @(negedge clk);
    endtask

    task automatic window(input int n);
        gate_in = 1'b1; @(negedge clk);
        for (int i = 0; i < n; i++) ev_pulse();
        @(negedge clk);
        gate_in = 1'b0; repeat (8) @(negedge clk);
    endtask

    task automatic strobe();
        sample_strobe = 1'b1; @(negedge clk);
        sample_strobe = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clear();
        clear_flags = 1'b1; @(negedge clk);
        clear_flags = 1'b0; @(negedge clk);
    endtask

    task automatic pop_expect(input int exp, input logic exp_sat, input string tag);
        for (int i = 0; i < 50 && !out_valid; i++) @(negedge clk);
        check(out_valid, {tag, " valid"}, out_valid, 1);
        check(out_count == CW'(exp), {tag, " count"}, out_count, exp);
        check(out_sat == exp_sat, {tag, " sat"}, out_sat, exp_sat);
        out_ready = 1'b1; @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        repeat (6) @(negedge clk);
        check(!out_valid, {tag, " queue empty"}, out_valid, 0);
    endtask

    // R1: reset state, and reset wipes the remembered sample and the flags.
    task automatic t_reset();
        do_reset();
        check(!out_valid, "R1 valid after reset", out_valid, 0);
        check(!err_gap && !err_overrun, "R1 flags after reset", {err_gap, err_overrun}, 0);
        win_mode = 2'b00; window(2); pop_expect(2, 0, "R1 setup");
        do_reset();
        window(0); pop_expect(0, 0, "R1 previous sample cleared");
    endtask

    // R2 R3 R4 R6 R11: per-window counting in zero policy.
    task automatic t_window();
        do_reset(); win_mode = 2'b01;
        window(3); pop_expect(3, 0, "R2 three events");
        ev_pulse(); ev_pulse(); repeat (4) @(negedge clk);
        expect_empty("R2 no sample without gate");
        window(1); pop_expect(1, 0, "R3 restart, outside edges ignored");
        gate_in = 1'b1; @(negedge clk); ev_pulse();
        gate_in = 1'b0; event_in = 1'b1; repeat (2) @(negedge clk);
        event_in = 1'b0; repeat (8) @(negedge clk);
        pop_expect(2, 0, "R4 closing-cycle edge counted");
        window(0); pop_expect(0, 0, "R6 empty window zero");
        gate_in = 1'b1; event_in = 1'b1; repeat (4) @(negedge clk);
        event_in = 1'b0; @(negedge clk); gate_in = 1'b0; repeat (95) @(negedge clk);
        pop_expect(1, 0, "R11 40ns pulse in 50ns gate");
        gate_in = 1'b1; repeat (5) @(negedge clk); gate_in = 1'b0; repeat (95) @(negedge clk);
        pop_expect(0, 0, "R11 empty 50ns gate");
    endtask

    // R5: repeat policy.
    task automatic t_repeat();
        do_reset(); win_mode = 2'b00;
        window(2); pop_expect(2, 0, "R5 first");
        window(0); pop_expect(2, 0, "R5 repeated");
        window(1); pop_expect(1, 0, "R5 new value");
    endtask

    // R7: strict policy.
    task automatic t_strict();
        do_reset(); win_mode = 2'b10;
        window(1); pop_expect(1, 0, "R7 normal window");
        window(0); expect_empty("R7 gap window dropped");
        check(err_gap, "R7 gap flag set", err_gap, 1);
        window(1); pop_expect(1, 0, "R7 after gap");
        check(err_gap, "R7 gap flag sticky", err_gap, 1);
        pulse_clear();
        check(!err_gap, "R7 gap flag cleared", err_gap, 0);
    endtask

    // R8: accumulate mode.
    task automatic t_accum();
        do_reset(); accum_mode = 1'b1;
        window(2); ev_pulse(); ev_pulse(); repeat (4) @(negedge clk); window(3);
        expect_empty("R8 closings emit nothing");
        strobe(); pop_expect(5, 0, "R8 total across windows");
        window(1); strobe(); pop_expect(6, 0, "R8 not cleared by gate");
        accum_mode = 1'b0;
    endtask

    // R9: saturation.
    task automatic t_sat();
        do_reset(); accum_mode = 1'b1;
        window(70); strobe(); pop_expect(63, 1, "R9 accumulate saturates");
        do_reset(); accum_mode = 1'b0; win_mode = 2'b01;
        window(63); pop_expect(63, 0, "R9 exact all ones no flag");
        window(64); pop_expect(63, 1, "R9 window overflow flagged");
    endtask

    // R10: queue depth, drop and sticky overrun.
    task automatic t_fifo();
        do_reset(); win_mode = 2'b01;
        for (int i = 0; i < 10; i++) window(1);
        check(err_overrun, "R10 overrun set", err_overrun, 1);
        for (int i = 0; i < 8; i++) pop_expect(1, 0, "R10 queued sample");
        expect_empty("R10 extra samples dropped");
        check(err_overrun, "R10 overrun sticky", err_overrun, 1);
        pulse_clear();
        check(!err_overrun, "R10 overrun cleared", err_overrun, 0);
    endtask

    initial begin
        t_reset();
        t_window();
        t_repeat();
        t_strict();
        t_accum();
        t_sat();
        t_fifo();
        summary();
    end
endmodule